// File: doc/BRIEF.md
# Receive Endpoint FIFO with Free-Space Warning

This block buffers the bytes of one receive endpoint. An endpoint controller pushes each received byte on the write side. Software pops bytes through a register-style read port. A packet may be longer than the buffer, so software drains bytes while the packet is still arriving. The block tells software how many bytes it can read and how many more the buffer can take. It warns when that headroom drops to a programmable level. It also latches an overrun when a byte arrives with no room left.

The logical depth is a runtime value between one and the physical RAM depth, and it need not be a power of two. Both pointers wrap at that value. The depth is taken from the configuration input only while the buffer is flushed. A read past the stored data does not move anything: the read port keeps showing the byte it showed last.

Top module: `rx_ep_fifo`

## Requirements
- R1: After reset the readable count is 0, the free level equals DEPTH, the read data is 0, and the overrun flag, warning flag and interrupt are all 0.
- R2: Bytes are read out in the order they were written. The byte taken by a read appears on `rd_data` in the cycle after `rd_en` is sampled.
- R3: `rd_count` equals the number of stored bytes, and `free_level` equals the active size minus `rd_count`. Both update in the cycle after the write or read.
- R4: A read while `rd_count` is 0 changes nothing. `rd_data` keeps its previous value and the count stays 0.
- R5: A write while the buffer is full and no read is accepted in the same cycle is dropped, and the stored bytes are unchanged. `ovr_flag` is 1 from the next cycle on. It stays 1 until a cycle with `ovr_clr` and no new overrun, or until a flush.
- R6: A cycle with `flush` high empties the buffer and clears `ovr_flag`. It also loads the active size from `cfg_size`: 0 becomes 1, and values above DEPTH become DEPTH. The new size is in effect from the next cycle.
- R7: When `free_level <= warn_level` in a cycle, `warn_flag` is 1 from the next cycle on. It stays 1 until a `warn_clr` cycle in which the condition no longer holds.
- R8: `warn_irq` is high exactly when `warn_flag` is 1 and `warn_mask` is 0 (a mask value of 1 blocks it).
- R9: The pointers wrap at the active size, so with a size that is not a power of two the byte order holds across many wraps.
- R10: When a read is accepted in the same cycle as a write, the count does not change. At full, that write is stored and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empties the buffer, clears overrun, loads size |
| cfg_size | input | CNT_W | Requested logical depth, sampled on flush |
| warn_level | input | CNT_W | Free-space threshold for the warning |
| wr_en | input | 1 | Endpoint-side byte write strobe |
| wr_data | input | DATA_W | Byte to store |
| rd_en | input | 1 | Software read strobe |
| rd_data | output | DATA_W | Byte from the last accepted read |
| rd_count | output | CNT_W | Bytes available to read |
| free_level | output | CNT_W | Bytes that can still be accepted |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| ovr_flag | output | 1 | Sticky overrun indication |
| warn_clr | input | 1 | Write-one-to-clear for the warning flag |
| warn_mask | input | 1 | Blocks the warning interrupt when 1 |
| warn_flag | output | 1 | Sticky free-space warning |
| warn_irq | output | 1 | Masked warning interrupt |

## Verification
The hardest case to reach is the cycle where the buffer is exactly full and a read and a write land together. The write must then be stored, with no overrun. The stimulus gets there by setting a small size with a flush, filling to the brim, and then raising both strobes in one cycle. A size of five, streamed in short bursts, forces the pointers through many wraps at a point that is not a power of two. A size request of zero and one above DEPTH check the clamp.

// File: rtl/rx_ep_fifo_pkg.sv
package rx_ep_fifo_pkg;
  // next pointer position with wrap at the active size
  function automatic int ring_next(input int pos, input int size);
    return (pos + 1 >= size) ? 0 : pos + 1;
  endfunction

  // bound a requested size into 1..depth
  function automatic int size_clamp(input int req, input int depth);
    if (req < 1) return 1;
    if (req > depth) return depth;
    return req;
  endfunction

  // headroom left before an overrun
  function automatic int headroom(input int size, input int fill);
    return size - fill;
  endfunction
endpackage

// File: rtl/rx_ep_ptr_ctrl.sv
module rx_ep_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [CNT_W-1:0] cfg_size,
  input  logic             wr_en,
  input  logic             rd_en,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] fill,
  output logic [CNT_W-1:0] size,
  output logic             wr_ok,
  output logic             rd_ok,
  output logic             ovr_evt
);
  import rx_ep_fifo_pkg::*;

  logic full;

  assign full    = (fill == size);
  assign rd_ok   = rd_en && !flush && (fill != '0);
  assign wr_ok   = wr_en && !flush && (!full || rd_ok);
  assign ovr_evt = wr_en && !flush && full && !rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      size <= CNT_W'(DEPTH);
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      size <= CNT_W'(size_clamp(int'(cfg_size), DEPTH));
    end else begin
      if (wr_ok) wptr <= PTR_W'(ring_next(int'(wptr), int'(size)));
      if (rd_ok) rptr <= PTR_W'(ring_next(int'(rptr), int'(size)));
      if (wr_ok && !rd_ok) fill <= fill + 1'b1;
      else if (rd_ok && !wr_ok) fill <= fill - 1'b1;
    end
  end

  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= size);
  a_r6_size_range: assert property (@(posedge clk) disable iff (!rst_n)
    (size >= 1) && (int'(size) <= DEPTH));
  a_r4_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !flush && fill == '0) |=> (rptr == $past(rptr)));
  a_r6_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0 && wptr == '0 && rptr == '0));
  a_r10_same_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && rd_ok) |=> $stable(fill));
endmodule

// File: rtl/rx_ep_store.sv
module rx_ep_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_ok,
  input  logic [PTR_W-1:0]  rptr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rptr];
  end

  a_r4_repeat_last: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |=> $stable(rd_data));
endmodule

// File: rtl/rx_ep_flags.sv
module rx_ep_flags #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ovr_evt,
  input  logic             ovr_clr,
  input  logic [CNT_W-1:0] free_level,
  input  logic [CNT_W-1:0] warn_level,
  input  logic             warn_clr,
  output logic             ovr_flag,
  output logic             warn_flag
);
  logic warn_hit;

  assign warn_hit = (free_level <= warn_level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag  <= 1'b0;
      warn_flag <= 1'b0;
    end else begin
      if (flush) ovr_flag <= 1'b0;
      else ovr_flag <= (ovr_flag && !ovr_clr) || ovr_evt;
      warn_flag <= (warn_flag && !warn_clr) || warn_hit;
    end
  end

  a_r5_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_flag);
  a_r5_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr && !flush) |=> ovr_flag);
  a_r6_ovr_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ovr_flag);
  a_r7_warn_set: assert property (@(posedge clk) disable iff (!rst_n)
    warn_hit |=> warn_flag);
  a_r7_warn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (warn_flag && !warn_clr) |=> warn_flag);
endmodule

// File: rtl/rx_ep_fifo.sv
module rx_ep_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic [CNT_W-1:0]  warn_level,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_count,
  output logic [CNT_W-1:0]  free_level,
  input  logic              ovr_clr,
  output logic              ovr_flag,
  input  logic              warn_clr,
  input  logic              warn_mask,
  output logic              warn_flag,
  output logic              warn_irq
);
  import rx_ep_fifo_pkg::*;

  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] fill, size;
  logic             wr_ok, rd_ok, ovr_evt;

  rx_ep_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_size(cfg_size),
    .wr_en(wr_en), .rd_en(rd_en), .wptr(wptr), .rptr(rptr),
    .fill(fill), .size(size), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .ovr_evt(ovr_evt)
  );

  rx_ep_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wptr(wptr),
    .wr_data(wr_data), .rd_ok(rd_ok), .rptr(rptr), .rd_data(rd_data)
  );

  assign rd_count   = fill;
  assign free_level = CNT_W'(headroom(int'(size), int'(fill)));
  assign warn_irq   = warn_flag && !warn_mask;

  rx_ep_flags #(.CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ovr_evt(ovr_evt),
    .ovr_clr(ovr_clr), .free_level(free_level), .warn_level(warn_level),
    .warn_clr(warn_clr), .ovr_flag(ovr_flag), .warn_flag(warn_flag)
  );

  a_r5_drop_keeps_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !rd_en) |=> $stable(rd_count));
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    warn_mask |-> !warn_irq);
endmodule

// File: tb/sim_rx_ep_fifo.sv
module sim_rx_ep_fifo;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, flush = 0, wr_en = 0, rd_en = 0;
  logic ovr_clr = 0, warn_clr = 0, warn_mask = 0;
  logic [CW-1:0] cfg_size = CW'(DEPTH), warn_level = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [CW-1:0] rd_count, free_level;
  logic ovr_flag, warn_flag, warn_irq;

  int checks = 0, errors = 0;
  bit done = 0;
  byte unsigned q[$];
  int sz = DEPTH;
  int exp_data = 0;
  bit ovr_m = 0;

  always #4 clk = ~clk;

  rx_ep_fifo #(.DEPTH(DEPTH), .DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_size(cfg_size),
    .warn_level(warn_level), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_count(rd_count),
    .free_level(free_level), .ovr_clr(ovr_clr), .ovr_flag(ovr_flag),
    .warn_clr(warn_clr), .warn_mask(warn_mask), .warn_flag(warn_flag),
    .warn_irq(warn_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one cycle of traffic, checked against a queue model
  task automatic step(input bit wr, input int d, input bit rd, input bit clr,
                      input string tag);
    int n = q.size();
    bit r = rd && n > 0;
    bit w = wr && (n < sz || r);
    wr_en = wr; wr_data = 8'(d); rd_en = rd; ovr_clr = clr;
    tick();
    wr_en = 0; rd_en = 0; ovr_clr = 0;
    if (r) exp_data = q.pop_front();
    if (w) q.push_back(8'(d));
    ovr_m = (ovr_m && !clr) || (wr && !w);
    chk({tag, " data"}, rd_data, exp_data);
    chk("R3 count", rd_count, q.size());
    chk("R3 free", free_level, sz - q.size());
    chk("R5 ovr", ovr_flag, ovr_m);
  endtask

  task automatic do_flush(input int req);
    cfg_size = CW'(req); flush = 1;
    tick();
    flush = 0;
    q.delete();
    ovr_m = 0;
    sz = (req < 1) ? 1 : (req > DEPTH ? DEPTH : req);
    chk("R6 flush count", rd_count, 0);
    chk("R6 flush ovr", ovr_flag, 0);
    chk("R6 size", free_level, sz);
  endtask

  task automatic t_reset();
    chk("R1 count", rd_count, 0);
    chk("R1 free", free_level, DEPTH);
    chk("R1 data", rd_data, 0);
    chk("R1 ovr", ovr_flag, 0);
    chk("R1 warn", warn_flag, 0);
    chk("R1 irq", warn_irq, 0);
  endtask

  task automatic t_order();
    do_flush(DEPTH);
    for (int i = 0; i < 5; i++) step(1, 8'h30 + i, 0, 0, "R2");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, "R2");
  endtask

  task automatic t_underrun();
    step(0, 0, 1, 0, "R4 underrun");
    step(0, 0, 1, 0, "R4 underrun");
    chk("R4 last byte", rd_data, 8'h34);
  endtask

  task automatic t_overrun();
    do_flush(4);
    for (int i = 0; i < 4; i++) step(1, 8'h50 + i, 0, 0, "R5");
    step(1, 8'hEE, 0, 0, "R5 drop");
    step(0, 0, 0, 0, "R5 sticky");
    step(1, 8'hEF, 0, 1, "R5 set wins");
    step(0, 0, 0, 1, "R5 clear");
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "R5 contents");
    for (int i = 0; i < 5; i++) step(1, 8'h60 + i, 0, 0, "R5 refill");
    chk("R5 refilled ovr", ovr_flag, 1);
    do_flush(4);
  endtask

  task automatic t_clamp();
    do_flush(0);
    step(1, 8'hA1, 0, 0, "R6 size1");
    step(1, 8'hA2, 0, 0, "R6 size1 full");
    step(0, 0, 1, 0, "R6 size1 read");
    do_flush(DEPTH + 4);
  endtask

  task automatic t_warn();
    warn_level = CW'(3);
    do_flush(8);
    warn_clr = 1; tick(); warn_clr = 0;
    chk("R7 cleared", warn_flag, 0);
    for (int i = 0; i < 4; i++) step(1, i, 0, 0, "R7 fill");
    chk("R7 above level", warn_flag, 0);
    step(1, 4, 0, 0, "R7 reach");
    chk("R7 latency", warn_flag, 0);
    step(0, 0, 0, 0, "R7 idle");
    chk("R7 set", warn_flag, 1);
    warn_mask = 1; #1;
    chk("R8 masked", warn_irq, 0);
    warn_mask = 0; #1;
    chk("R8 unmasked", warn_irq, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R7 drain");
    chk("R7 sticky", warn_flag, 1);
    warn_clr = 1; tick(); warn_clr = 0;
    chk("R7 clr", warn_flag, 0);
    chk("R8 irq off", warn_irq, 0);
    warn_level = '0;
  endtask

  task automatic t_wrap();
    do_flush(5);
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 3; i++) step(1, 16 * k + i, 0, 0, "R9");
      for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R9 wrap order");
    end
  endtask

  task automatic t_concurrent();
    do_flush(3);
    for (int i = 0; i < 3; i++) step(1, 8'hC0 + i, 0, 0, "R10 fill");
    step(1, 8'hCA, 1, 0, "R10 full rw");
    chk("R10 no ovr", ovr_flag, 0);
    chk("R10 count", rd_count, 3);
    step(1, 8'hCB, 1, 0, "R10 rw");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, "R10 drain");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_order();
    t_underrun();
    t_overrun();
    t_clamp();
    t_warn();
    t_wrap();
    t_concurrent();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule